// File: doc/BRIEF.md
# Delay-Slot-Aware Instruction Fetch Stage

This block is the front end of a single-thread pipeline whose instruction set has architectural branch delay slots. It keeps three program-counter registers (current, next and next-next), one line-sized instruction buffer and a small delay-slot tracker. Each cycle it hands a group of consecutive instructions from the buffer to decode. Each instruction carries its address, its word and a sequence number.

For every slot the stage presents the slot address to an external branch predictor. The predictor answers through four signals: control, taken, annul and target. A predicted-taken branch does not redirect at once. The stage first fetches the delay-slot instruction that follows the branch, and only then loads the recorded target, even when that delay slot lies in the next line. A squash from later stages redirects the stage and cancels a pending line miss. It also clears the delay-slot tracker when the squash sequence number is not younger than the last predicted branch.

Line misses go to an instruction memory through a valid-only request and response pair, with at most one request outstanding. A response that belongs to a cancelled miss is discarded. Instructions are 4 bytes. Word i of a line sits in response bits [32*i+31:32*i].

Top module: `dslot_fetch`

## Requirements
- R1: After reset the current PC equals RESET_VEC, the next PC equals RESET_VEC+4 and the next-next PC equals RESET_VEC+8. No slot is valid.
- R2: A request is issued only when the buffer does not hold the line of the current PC. The request address is that line's base, with the low log2(LINE_BYTES) bits zero. At most one request is outstanding. A line already held causes no request.
- R3: Slot k (0 <= k < FETCH_W) holds address PC+4k and word (index of PC within the line)+k of the buffer. Valid slots are packed from slot 0. Without branches, a cycle emits up to FETCH_W consecutive instructions and the PC advances by 4 per instruction emitted.
- R4: Emission within a cycle stops at the last word of the line. The next cycle starts at the first word of the following line.
- R5: Each emitted instruction carries a 16-bit sequence number one greater than that of the previous emitted instruction, wrapping from 65535 to 0. Squashes do not reset the number.
- R6: After a predicted-taken branch the next instruction (the delay slot) is still emitted, and emission stops after it. The current, next and next-next PC then become target, target+4 and target+8.
- R7: When a predicted-taken branch is the last word of a line, its delay slot is fetched first from the following line. The redirect to the target follows after that delay slot.
- R8: A control instruction predicted not taken and not annulling lets emission continue with the following address.
- R9: A control instruction predicted not taken and annulling moves the PC to the predictor's target (its fall-through address). The instruction right after it is not emitted.
- R10: A squash sets current, next and next-next PC to the redirect address, +4 and +8. No slot is valid in the squash cycle.
- R11: A squash whose sequence number is less than or equal to the sequence number of the last predicted-taken branch drops a pending delay-slot redirect. A squash with a larger number keeps it, and the redirect then follows the next instruction emitted.
- R12: A squash during an outstanding miss cancels it. The late response is dropped and the line is requested again.
- R13: While fetch_stall is high, no slot is valid, no request is issued and the PC registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Line request strobe |
| mem_req_addr | output | 32 | Line-aligned request address |
| mem_rsp_valid | input | 1 | Line response strobe |
| mem_rsp_data | input | LINE_BYTES*8 | Line data, word i in bits [32i+31:32i] |
| lk_pc | output | FETCH_W*32 | Slot addresses presented to the predictor |
| bp_ctrl | input | FETCH_W | Slot holds a control instruction |
| bp_taken | input | FETCH_W | Predicted taken |
| bp_annul | input | FETCH_W | Branch annuls its delay slot when not taken |
| bp_target | input | FETCH_W*32 | Taken target, or fall-through address when annulled |
| fetch_stall | input | 1 | Fault stall, freezes emission and requests |
| sq_valid | input | 1 | Squash strobe |
| sq_addr | input | 32 | Squash redirect address |
| sq_seq | input | 16 | Sequence number of the squashing instruction |
| out_valid | output | FETCH_W | Slot carries an instruction |
| out_pc | output | FETCH_W*32 | Slot instruction addresses |
| out_insn | output | FETCH_W*32 | Slot instruction words |
| out_seq | output | FETCH_W*16 | Slot sequence numbers |
| cur_pc | output | 32 | Current PC |
| cur_npc | output | 32 | Next PC |
| cur_nnpc | output | 32 | Next-next PC |

## Verification
The assertions assume that every redirect address and predictor target is word aligned. They also assume that the predictor never reports a taken branch in a delay slot, and that memory sends exactly one response per request. The bench's predictor is a fixed function of the slot address. It places control instructions only at chosen addresses and never right after a taken branch. Its memory model answers each request once, after a fixed latency. Squash addresses are always multiples of four.

// File: rtl/dslot_fetch.sv
module dslot_fetch #(
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  parameter int LINE_BYTES = 16,
  parameter int FETCH_W = 2,
  parameter int SEQ_W = 16,
  parameter int DS_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    mem_req_valid,
  output logic [31:0]             mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rsp_data,
  output logic [FETCH_W*32-1:0]   lk_pc,
  input  logic [FETCH_W-1:0]      bp_ctrl,
  input  logic [FETCH_W-1:0]      bp_taken,
  input  logic [FETCH_W-1:0]      bp_annul,
  input  logic [FETCH_W*32-1:0]   bp_target,
  input  logic                    fetch_stall,
  input  logic                    sq_valid,
  input  logic [31:0]             sq_addr,
  input  logic [SEQ_W-1:0]        sq_seq,
  output logic [FETCH_W-1:0]      out_valid,
  output logic [FETCH_W*32-1:0]   out_pc,
  output logic [FETCH_W*32-1:0]   out_insn,
  output logic [FETCH_W*SEQ_W-1:0] out_seq,
  output logic [31:0]             cur_pc,
  output logic [31:0]             cur_npc,
  output logic [31:0]             cur_nnpc
);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = OFF_W - 2;

  logic [31:0] pc, npc, nnpc, tag, ds_tgt;
  logic        lvalid, pend, stale, ds_rdy;
  logic [DS_W-1:0]  ds_cnt;
  logic [SEQ_W-1:0] br_seq, seq;
  logic [LINE_BYTES*8-1:0] line_q;
  logic [31:0] lw [WORDS];

  logic [31:0] e_next, e_nn, e_tgt, slot_pc;
  logic [DS_W-1:0]  e_cnt;
  logic             e_rdy, run;
  logic [SEQ_W-1:0] e_bseq, e_n;

  wire [31:0] line_base = {pc[31:OFF_W], {OFF_W{1'b0}}};
  wire        hit = lvalid && (tag == line_base);
  wire        go = hit && !fetch_stall && !sq_valid;

  assign mem_req_valid = !hit && !pend && !fetch_stall && !sq_valid;
  assign mem_req_addr  = line_base;
  assign cur_pc   = pc;
  assign cur_npc  = npc;
  assign cur_nnpc = nnpc;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign lw[w] = line_q[w*32 +: 32];
  end

  for (genvar k = 0; k < FETCH_W; k++) begin : g_lk
    assign lk_pc[k*32 +: 32] = pc + 32'(4 * k);
  end

  always_comb begin
    e_next = pc;
    e_nn   = npc;
    e_tgt  = ds_tgt;
    e_cnt  = ds_cnt;
    e_rdy  = ds_rdy;
    e_bseq = br_seq;
    e_n    = '0;
    run    = go;
    slot_pc = pc;
    out_valid = '0;
    out_pc = '0;
    out_insn = '0;
    out_seq = '0;
    for (int k = 0; k < FETCH_W; k++) begin
      slot_pc = pc + 32'(4 * k);
      out_pc[k*32 +: 32]   = slot_pc;
      out_insn[k*32 +: 32] = lw[pc[OFF_W-1:2] + IDX_W'(k)];
      out_seq[k*SEQ_W +: SEQ_W] = seq + e_n;
      if (run && (int'(pc[OFF_W-1:2]) + k < WORDS) && (slot_pc == e_next)) begin
        out_valid[k] = 1'b1;
        e_n = e_n + 1'b1;
        if (!bp_ctrl[k]) begin
          e_next = slot_pc + 32'd4;
          e_nn   = slot_pc + 32'd8;
        end else if (bp_taken[k]) begin
          e_next = e_nn;
          e_nn   = bp_target[k*32 +: 32];
          e_tgt  = bp_target[k*32 +: 32];
          e_cnt  = e_cnt + 1'b1;
          e_bseq = out_seq[k*SEQ_W +: SEQ_W];
        end else begin
          e_next = bp_annul[k] ? bp_target[k*32 +: 32] : e_nn;
          e_nn   = e_next + 32'd4;
        end
        if (!(bp_ctrl[k] && bp_taken[k]) && (e_cnt != '0)) begin
          e_cnt = e_cnt - 1'b1;
          if (e_cnt == '0) begin
            e_rdy = 1'b1;
            run   = 1'b0;
          end
        end
      end else begin
        run = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= RESET_VEC;
      npc <= RESET_VEC + 32'd4;
      nnpc <= RESET_VEC + 32'd8;
      tag <= '0;
      lvalid <= 1'b0;
      pend <= 1'b0;
      stale <= 1'b0;
      line_q <= '0;
      ds_cnt <= '0;
      ds_tgt <= '0;
      ds_rdy <= 1'b0;
      br_seq <= '0;
      seq <= '0;
    end else begin
      if (sq_valid) begin
        pc <= sq_addr;
        npc <= sq_addr + 32'd4;
        nnpc <= sq_addr + 32'd8;
        if (sq_seq <= br_seq) begin
          ds_cnt <= '0;
          ds_tgt <= '0;
          ds_rdy <= 1'b0;
        end
      end else if (e_n != '0) begin
        seq <= seq + e_n;
        ds_cnt <= e_cnt;
        br_seq <= e_bseq;
        ds_tgt <= e_tgt;
        if (e_rdy && e_cnt == '0) begin
          pc <= e_tgt;
          npc <= e_tgt + 32'd4;
          nnpc <= e_tgt + 32'd8;
          ds_rdy <= 1'b0;
        end else begin
          pc <= e_next;
          npc <= e_nn;
          nnpc <= e_nn + 32'd4;
          ds_rdy <= e_rdy;
        end
      end
      if (mem_req_valid) begin
        pend <= 1'b1;
        tag <= line_base;
        lvalid <= 1'b0;
      end
      if (mem_rsp_valid && pend) begin
        pend <= 1'b0;
        stale <= 1'b0;
        if (!stale && !sq_valid) begin
          lvalid <= 1'b1;
          line_q <= mem_rsp_data;
        end
      end else if (sq_valid && pend) begin
        stale <= 1'b1;
      end
    end
  end

  a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  a_r10_squash_pc: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> (cur_pc == $past(sq_addr)) && (cur_nnpc == $past(sq_addr) + 32'd8));

  a_r10_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> out_valid == '0);

  a_r13_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && !sq_valid) |=> $stable(cur_pc) && $stable(cur_npc));

  for (genvar k = 1; k < FETCH_W; k++) begin : g_pack
    a_r3_packed: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] |-> out_valid[k-1]);
  end
endmodule

// File: tb/dslot_fetch_tb.sv
module dslot_fetch_tb;
  localparam int LB = 16;
  localparam int FW = 2;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic mem_req_valid, mem_rsp_valid;
  logic [31:0] mem_req_addr;
  logic [LB*8-1:0] mem_rsp_data;
  logic [FW*32-1:0] lk_pc, bp_target, out_pc, out_insn;
  logic [FW-1:0] bp_ctrl, bp_taken, bp_annul, out_valid;
  logic fetch_stall = 1'b1, sq_valid = 1'b0;
  logic [31:0] sq_addr = '0;
  logic [15:0] sq_seq = '0;
  logic [FW*16-1:0] out_seq;
  logic [31:0] cur_pc, cur_npc, cur_nnpc;

  dslot_fetch u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .lk_pc(lk_pc), .bp_ctrl(bp_ctrl), .bp_taken(bp_taken),
    .bp_annul(bp_annul), .bp_target(bp_target),
    .fetch_stall(fetch_stall), .sq_valid(sq_valid), .sq_addr(sq_addr),
    .sq_seq(sq_seq), .out_valid(out_valid), .out_pc(out_pc),
    .out_insn(out_insn), .out_seq(out_seq),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_nnpc(cur_nnpc)
  );

  function automatic logic [31:0] word_of(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // {ctrl, taken, annul, target}
  function automatic logic [34:0] pred(logic [31:0] a);
    case (a)
      32'h3000: return {3'b110, 32'h3000};
      32'h200C: return {3'b110, 32'h2400};
      32'h2800: return {3'b100, 32'h2804};
      32'h2C00: return {3'b101, 32'h2C08};
      32'h340C: return {3'b110, 32'h3800};
      default:  return {3'b000, 32'h0};
    endcase
  endfunction

  always_comb begin
    for (int k = 0; k < FW; k++)
      {bp_ctrl[k], bp_taken[k], bp_annul[k], bp_target[k*32 +: 32]} = pred(lk_pc[k*32 +: 32]);
  end

  int nreq = 0;
  int mcnt = 0;
  logic [31:0] maddr = '0;
  logic [31:0] last_req = '0;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (!rst_n) mcnt <= 0;
    else if (mem_req_valid) begin
      maddr <= mem_req_addr;
      last_req <= mem_req_addr;
      mcnt <= LAT;
      nreq <= nreq + 1;
    end else if (mcnt != 0) begin
      mcnt <= mcnt - 1;
      if (mcnt == 1) begin
        mem_rsp_valid <= 1'b1;
        for (int i = 0; i < LB/4; i++)
          mem_rsp_data[i*32 +: 32] <= word_of(maddr + 32'(4*i));
      end
    end
  end

  typedef struct {
    logic [31:0] pc;
    logic [15:0] seq;
    int          k;
    string       req;
  } item_t;
  item_t q[$];
  int nchk = 0, nerr = 0;
  logic [15:0] eseq = '0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < FW; k++) begin
        if (out_valid[k]) begin
          if (q.size() == 0) begin
            chk(0, "R3", "unexpected slot pc", 64'(out_pc[k*32 +: 32]), 64'h0);
          end else begin
            item_t it;
            it = q.pop_front();
            chk(out_pc[k*32 +: 32] == it.pc && k == it.k, it.req, "slot pc/index",
                {32'(k), out_pc[k*32 +: 32]}, {32'(it.k), it.pc});
            chk(out_insn[k*32 +: 32] == word_of(it.pc), "R3", "insn",
                64'(out_insn[k*32 +: 32]), 64'(word_of(it.pc)));
            chk(out_seq[k*16 +: 16] == it.seq, "R5", "seq",
                64'(out_seq[k*16 +: 16]), 64'(it.seq));
          end
        end
      end
    end
  end

  task automatic exp(logic [31:0] a, int k, string req);
    q.push_back('{a, eseq, k, req});
    eseq = eseq + 16'd1;
  endtask

  task automatic squash(logic [31:0] a, logic [15:0] s);
    @(posedge clk); #1;
    sq_valid = 1'b1; sq_addr = a; sq_seq = s;
    #1;
    chk(out_valid == '0, "R10", "valid during squash", 64'(out_valid), 64'h0);
    @(posedge clk); #1;
    sq_valid = 1'b0;
    chk(cur_pc == a && cur_npc == a + 4 && cur_nnpc == a + 8, "R10", "pc after squash",
        {cur_pc, cur_nnpc}, {a, a + 32'd8});
  endtask

  task automatic go_wait(int limit);
    int t;
    t = 0;
    @(posedge clk); #1;
    fetch_stall = 1'b0;
    while (q.size() != 0 && t < limit) begin
      @(posedge clk); #1;
      t++;
    end
    fetch_stall = 1'b1;
    chk(q.size() == 0, "R3", "expected items left", 64'(q.size()), 64'h0);
    q.delete();
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [15:0] s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state, R13 stall holds everything
    chk(cur_pc == 32'h1000 && cur_npc == 32'h1004 && cur_nnpc == 32'h1008, "R1", "reset pcs",
        {cur_pc, cur_nnpc}, {32'h1000, 32'h1008});
    chk(out_valid == '0, "R1", "reset valid", 64'(out_valid), 64'h0);
    repeat (3) @(posedge clk); #1;
    chk(nreq == 0 && mem_req_valid == 1'b0, "R13", "request while stalled", 64'(nreq), 64'h0);
    chk(cur_pc == 32'h1000, "R13", "pc hold under stall", 64'(cur_pc), 64'h1000);

    // R2 R3 two aligned lines
    n0 = nreq;
    for (int i = 0; i < 8; i++) exp(32'h1000 + 32'(4*i), i % 2, "R3");
    go_wait(200);
    chk(nreq == n0 + 2, "R2", "request count", 64'(nreq), 64'(n0 + 2));
    chk(last_req == 32'h1010, "R2", "aligned request", 64'(last_req), 64'h1010);

    // R4 unaligned start, stop at line end
    squash(32'h1024, 16'd0);
    exp(32'h1024, 0, "R4"); exp(32'h1028, 1, "R4"); exp(32'h102C, 0, "R4");
    exp(32'h1030, 0, "R4"); exp(32'h1034, 1, "R4");
    go_wait(200);

    // R7 taken branch at last word, delay slot in next line
    squash(32'h2008, 16'd0);
    exp(32'h2008, 0, "R7"); exp(32'h200C, 1, "R7"); exp(32'h2010, 0, "R7");
    exp(32'h2400, 0, "R7"); exp(32'h2404, 1, "R7");
    go_wait(200);
    chk(cur_pc == 32'h2408 && cur_npc == 32'h240C, "R7", "pc after redirect",
        {cur_pc, cur_npc}, {32'h2408, 32'h240C});

    // R8 not taken, not annulling
    squash(32'h2800, 16'd0);
    exp(32'h2800, 0, "R8"); exp(32'h2804, 1, "R8"); exp(32'h2808, 0, "R8"); exp(32'h280C, 1, "R8");
    go_wait(200);

    // R9 not taken, annulling
    squash(32'h2C00, 16'd0);
    exp(32'h2C00, 0, "R9"); exp(32'h2C08, 0, "R9"); exp(32'h2C0C, 1, "R9");
    go_wait(200);

    // R11 squash at branch seq clears the pending redirect
    squash(32'h3408, 16'd0);
    exp(32'h3408, 0, "R7"); s = eseq; exp(32'h340C, 1, "R7");
    go_wait(200);
    squash(32'h3C00, s);
    exp(32'h3C00, 0, "R11"); exp(32'h3C04, 1, "R11"); exp(32'h3C08, 0, "R11"); exp(32'h3C0C, 1, "R11");
    go_wait(200);

    // R11 younger squash keeps it
    squash(32'h3408, 16'd0);
    exp(32'h3408, 0, "R7"); s = eseq; exp(32'h340C, 1, "R7");
    go_wait(200);
    squash(32'h3C00, s + 16'd1);
    exp(32'h3C00, 0, "R11"); exp(32'h3800, 0, "R11"); exp(32'h3804, 1, "R11");
    go_wait(200);

    // R12 squash during an outstanding miss
    n0 = nreq;
    squash(32'h4000, 16'd0);
    exp(32'h4000, 0, "R12"); exp(32'h4004, 1, "R12"); exp(32'h4008, 0, "R12"); exp(32'h400C, 1, "R12");
    @(posedge clk); #1;
    fetch_stall = 1'b0;
    squash(32'h4000, 16'd0);
    go_wait(200);
    chk(nreq == n0 + 2, "R12", "re-request after cancel", 64'(nreq), 64'(n0 + 2));

    // R6 R5 two-instruction loop through a taken branch, long enough to wrap seq
    n0 = nreq;
    squash(32'h3000, 16'd0);
    for (int i = 0; i < 32800; i++) begin
      exp(32'h3000, 0, "R6"); exp(32'h3004, 1, "R6");
    end
    go_wait(40000);
    chk(nreq == n0 + 1, "R2", "no request for held line", 64'(nreq), 64'(n0 + 1));
    chk(cur_pc == 32'h3000 && cur_npc == 32'h3004 && cur_nnpc == 32'h3008, "R6", "pcs at target",
        {cur_pc, cur_nnpc}, {32'h3000, 32'h3008});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule